// File: doc/BRIEF.md
# Three-Digit Latched Segment Display Interface

This block sits behind an 8-bit host output port and drives three seven-segment digits with a decimal point each. Only a shared data byte and one control line come from the host, plus a write strobe. A level on the control line steers each strobed byte either into a small select register or into the digit latches that this select register currently enables.

The host first writes a select byte with the control line low. In that byte, bit 5 enables the rightmost digit, bit 6 the middle digit and bit 7 the leftmost digit. It then raises the control line and writes the segment pattern. Each latch keeps its byte until the next write to it. Segment bytes are active low: a 0 bit lights its segment, and 0xFF leaves the digit dark.

Top module: `segbank_disp`

## Requirements
- R1: A synchronous reset sets all three segment outputs to 0xFF (blank).
- R2: Reset clears the select register, so a strobed write with the control line high after reset changes no digit.
- R3: A strobed write with the control line low loads the select register and leaves every segment output unchanged.
- R4: A strobed write with the control line high copies the data byte into each enabled digit. Select bit 5 maps to seg_n[7:0] (right), bit 6 to seg_n[15:8] (middle) and bit 7 to seg_n[23:16] (left). Digits that are not enabled keep their values.
- R5: When several select bits are set, one digit write updates all enabled digits in the same cycle.
- R6: Select bits 0 to 4 are ignored. A select byte of 0x1F enables no digit, and 0x7F enables only the right and middle digits.
- R7: Without the write strobe, changes on the data bus and on the control line leave all outputs unchanged.
- R8: Segment bytes are stored exactly as written, with no inversion. Writing 0xFF blanks the digit.
- R9: The select value persists across any number of digit writes until the next select write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_stb | input | 1 | Write strobe; bus captured when high |
| ctl_line | input | 1 | 0 routes bus to select register, 1 to enabled digits |
| data_in | input | 8 | Shared host data byte |
| seg_n | output | 24 | Active-low segment bytes: [7:0] right, [15:8] middle, [23:16] left |

## Verification
The select register has no output, so its contents can only be seen through later digit writes. The stimulus writes a select value and then a recognizable digit pattern, and it reads the mask back by checking which digits took the pattern. Select bytes with only the ignored low bits set, and bytes that mix low and high bits, are read back the same way. A digit write straight after reset is included to show that nothing is enabled at that point.

// File: rtl/segbank_pkg.sv
package segbank_pkg;

    typedef enum logic [1:0] {
        RT_IDLE  = 2'd0,
        RT_SEL   = 2'd1,
        RT_DIGIT = 2'd2
    } route_e;

endpackage

// File: rtl/segbank_sel_reg.sv
module segbank_sel_reg #(
    parameter int BUS_W   = 8,
    parameter int DIGITS  = 3,
    parameter int SEL_LSB = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BUS_W-1:0]  data,
    output logic [DIGITS-1:0] sel
);
    localparam int SEL_MSB = SEL_LSB + DIGITS - 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel <= '0;
        end else if (load) begin
            sel <= data[SEL_MSB:SEL_LSB];
        end
    end
endmodule

// File: rtl/segbank_digit.sv
module segbank_digit #(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [BUS_W-1:0] data,
    output logic [BUS_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '1;
        end else if (we) begin
            q <= data;
        end
    end
endmodule

// File: rtl/segbank_disp.sv
module segbank_disp #(
    parameter int BUS_W   = 8,
    parameter int DIGITS  = 3,
    parameter int SEL_LSB = 5
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_stb,
    input  logic                      ctl_line,
    input  logic [BUS_W-1:0]          data_in,
    output logic [DIGITS*BUS_W-1:0]   seg_n
);
    import segbank_pkg::*;

    route_e            route;
    logic [DIGITS-1:0] sel_q;
    logic [DIGITS-1:0] digit_we;
    logic              sel_load;

    always_comb begin
        unique case ({wr_stb, ctl_line})
            2'b10:   route = RT_SEL;
            2'b11:   route = RT_DIGIT;
            default: route = RT_IDLE;
        endcase
    end

    assign sel_load = (route == RT_SEL);

    segbank_sel_reg #(
        .BUS_W  (BUS_W),
        .DIGITS (DIGITS),
        .SEL_LSB(SEL_LSB)
    ) u_sel (
        .clk (clk),
        .rst (rst),
        .load(sel_load),
        .data(data_in),
        .sel (sel_q)
    );

    for (genvar k = 0; k < DIGITS; k++) begin : g_digit
        assign digit_we[k] = (route == RT_DIGIT) && sel_q[k];

        segbank_digit #(.BUS_W(BUS_W)) u_dig (
            .clk (clk),
            .rst (rst),
            .we  (digit_we[k]),
            .data(data_in),
            .q   (seg_n[k*BUS_W +: BUS_W])
        );
    end
endmodule

// File: rtl/segbank_disp_chk.sv
module segbank_disp_chk #(
    parameter int BUS_W   = 8,
    parameter int DIGITS  = 3,
    parameter int SEL_LSB = 5
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    wr_stb,
    input logic                    ctl_line,
    input logic [BUS_W-1:0]        data_in,
    input logic [DIGITS*BUS_W-1:0] seg_n,
    input logic [DIGITS-1:0]       sel_q
);
    localparam int SEL_MSB = SEL_LSB + DIGITS - 1;

    // R1
    p_reset_blank_r1: assert property (@(posedge clk)
        rst |=> (seg_n == '1));

    // R2
    p_reset_nosel_r2: assert property (@(posedge clk)
        rst |=> (sel_q == '0));

    // R7
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> $stable(seg_n));

    // R3
    p_sel_write_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && !ctl_line) |=> $stable(seg_n));

    // R6
    p_sel_field_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && !ctl_line) |=> (sel_q == $past(data_in[SEL_MSB:SEL_LSB])));

    // R9
    p_sel_persist_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && ctl_line) |=> $stable(sel_q));

    for (genvar k = 0; k < DIGITS; k++) begin : g_chk
        // R4
        p_digit_load_r4: assert property (@(posedge clk) disable iff (rst)
            (wr_stb && ctl_line && sel_q[k]) |=>
                (seg_n[k*BUS_W +: BUS_W] == $past(data_in)));
        // R4
        p_digit_keep_r4: assert property (@(posedge clk) disable iff (rst)
            (wr_stb && ctl_line && !sel_q[k]) |=>
                $stable(seg_n[k*BUS_W +: BUS_W]));
    end
endmodule

bind segbank_disp segbank_disp_chk #(
    .BUS_W  (BUS_W),
    .DIGITS (DIGITS),
    .SEL_LSB(SEL_LSB)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_stb  (wr_stb),
    .ctl_line(ctl_line),
    .data_in (data_in),
    .seg_n   (seg_n),
    .sel_q   (sel_q)
);

// File: tb/segbank_disp_tb.sv
module segbank_disp_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_stb = 1'b0;
    logic        ctl_line = 1'b0;
    logic [7:0]  data_in = 8'h00;
    logic [23:0] seg_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    segbank_disp dut_i (
        .clk     (clk),
        .rst     (rst),
        .wr_stb  (wr_stb),
        .ctl_line(ctl_line),
        .data_in (data_in),
        .seg_n   (seg_n)
    );

    // {req, ctl, data, expected seg_n}
    localparam int NV = 14;
    localparam logic [4+1+8+24-1:0] VEC [NV] = '{
        {4'd2, 1'b1, 8'hC0, 24'hFFFFFF}, // R2 nothing enabled after reset
        {4'd3, 1'b0, 8'h20, 24'hFFFFFF}, // R3 select right
        {4'd4, 1'b1, 8'hC0, 24'hFFFFC0}, // R4 right digit
        {4'd9, 1'b1, 8'h92, 24'hFFFF92}, // R9 select held
        {4'd3, 1'b0, 8'h40, 24'hFFFF92}, // R3 select middle
        {4'd4, 1'b1, 8'hF9, 24'hFFF992}, // R4 middle digit
        {4'd3, 1'b0, 8'h80, 24'hFFF992}, // R3 select left
        {4'd4, 1'b1, 8'hA4, 24'hA4F992}, // R4 left digit
        {4'd6, 1'b0, 8'h1F, 24'hA4F992}, // R6 low bits only
        {4'd6, 1'b1, 8'h00, 24'hA4F992}, // R6 nothing enabled
        {4'd3, 1'b0, 8'hE0, 24'hA4F992}, // R3 select all
        {4'd5, 1'b1, 8'h88, 24'h888888}, // R5 all three at once
        {4'd6, 1'b0, 8'h7F, 24'h888888}, // R6 right+middle
        {4'd8, 1'b1, 8'hFF, 24'h88FFFF}  // R8 blank pattern
    };

    task automatic check(input string req, input logic [23:0] exp);
        checks++;
        if (seg_n !== exp) begin
            errors++;
            $display("FAIL %s: seg_n=%h expected %h", req, seg_n, exp);
        end
    endtask

    task automatic strobe(input logic c, input logic [7:0] d);
        @(negedge clk);
        ctl_line = c;
        data_in  = d;
        wr_stb   = 1'b1;
        @(negedge clk);
        wr_stb   = 1'b0;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", 24'hFFFFFF);

        for (int i = 0; i < NV; i++) begin
            strobe(VEC[i][32], VEC[i][31:24]);
            check($sformatf("R%0d", VEC[i][36:33]), VEC[i][23:0]);
        end

        // R7: bus activity without strobe
        @(negedge clk);
        ctl_line = 1'b1; data_in = 8'h00;
        @(negedge clk);
        ctl_line = 1'b0; data_in = 8'hE0;
        @(negedge clk);
        check("R7", 24'h88FFFF);
        // R7: the select must not have changed either (still right+middle)
        strobe(1'b1, 8'h11);
        check("R7", 24'h881111);

        // R1 / R2: reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1", 24'hFFFFFF);
        strobe(1'b1, 8'h00);
        check("R2", 24'hFFFFFF);

        // R5: left and right together, middle untouched
        strobe(1'b0, 8'hA0);
        strobe(1'b1, 8'h3C);
        check("R5", 24'h3CFF3C);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule